// File: doc/BRIEF.md
# Two-Wire Debug Link Transaction Engine

This block is the host-side bit engine for a two-wire serial debug link. One pin carries a clock that the host generates. The other is a shared data line, presented here as separate output, output-enable and input signals. A client hands the engine one request at a time. Each request names the target port (debug or access), the direction, a two-bit register address and, for writes, a 32-bit word. The engine then runs the whole exchange on the link: an 8-bit header, a turnaround, a 3-bit acknowledge from the target, and then either 33 outgoing bits (data and parity) or 33 incoming bits that it checks for parity.

The link clock is derived from the system clock. Its half period is `div_cfg + 1` system cycles, and the value is latched when a request is accepted. Bits the host drives change when the link clock falls, and the target samples them when it rises. Bits the target drives change when the link clock rises, and the host samples them on the next fall. Between transfers the link clock rests high and the host drives the data line. When a transfer completes, the engine pulses `done` for one cycle and holds the acknowledge, the status code, the read word and the parity flag until the next request is accepted.

Top module: `dbg2w_engine`

## Requirements
- R1: Link slots 0 to 7 carry the header, least significant bit first. Bit 0 is 1, bit 1 is `req_ap`, bit 2 is `req_rd`, bit 3 is `req_addr[0]`, bit 4 is `req_addr[1]`, bit 5 is the XOR of bits 1 to 4, bit 6 is 0 and bit 7 is 1.
- R2: While no transfer is running, `lnk_clk` is 1 and `lnk_oe` is 1. The host changes `lnk_do` and `lnk_oe` only when `lnk_clk` falls, and it never changes them when `lnk_clk` rises.
- R3: Slot 8 is a turnaround with `lnk_oe` at 0. In slots 9 to 11 the target sends the acknowledge, least significant bit first. Each bit is sampled on the falling link edge that follows the slot. `lnk_oe` stays 0 through slot 12.
- R4: A write with acknowledge 3'b001 uses slot 12 as a turnaround. Slots 13 to 44 then carry `req_wdata` bits 0 to 31, and slot 45 carries their XOR, all with `lnk_oe` at 1.
- R5: A read with acknowledge 3'b001 samples 32 data bits from slots 12 to 43 and a parity bit from slot 44, with `lnk_oe` at 0 through slot 45 (the closing turnaround). The word is returned in `rsp_rdata`, which is 0 after any other transfer.
- R6: `rsp_perr` is 1 only after a read with acknowledge 3'b001 whose 33 received bits have odd XOR. Then `rsp_status` is 8. Otherwise `rsp_status` equals `{1'b0, rsp_ack}`.
- R7: For any acknowledge other than 3'b001, the data phase is skipped. Slot 12 is the last slot and is a turnaround with `lnk_oe` at 0. `rsp_ack` reports the received code (2 wait, 4 fault, 7 no target).
- R8: Each link half period lasts `div_cfg + 1` system cycles. `busy` stays high for (`div_cfg` + 1) × (2 × slots + 1) cycles, where slots is 46 for a full transfer and 13 for a short one.
- R9: A request is accepted only while `busy` is 0. Requests presented while `busy` is 1 are ignored, and the latched fields do not change. `done` is a one-cycle pulse, and the response outputs hold until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | DIV_W | Link half period minus one, in system cycles |
| req_valid | input | 1 | Request present |
| req_ap | input | 1 | 1 selects access port, 0 debug port |
| req_rd | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_ack | output | 3 | Received acknowledge code |
| rsp_status | output | 4 | Acknowledge code, or 8 on read parity error |
| rsp_rdata | output | 32 | Received read word |
| rsp_perr | output | 1 | Read parity mismatch |
| lnk_clk | output | 1 | Link clock |
| lnk_do | output | 1 | Data line value driven by host |
| lnk_oe | output | 1 | Host drives data line when 1 |
| lnk_di | input | 1 | Data line value seen by host |

## Verification
The third acknowledge sample and the choice between a data phase and an early finish fall on the same falling link edge. The bench provokes this by sweeping every acknowledge code for both reads and writes at three divider settings. It judges the result by counting link clock rises, checking the line direction at every rise, and checking the exact length of `busy`. A second pair of events is a new request arriving in the middle of a transfer. The bench changes every request field while `busy` is high and then confirms that the header, the write bits and the idle state after `done` are unaffected.

// File: rtl/dbg2w_pkg.sv
// Shared constants and helpers for the two-wire debug engine.
// Slot numbering: slot 0 is the first header bit; every slot is one link
// clock period that starts with a falling edge and ends with a rising one.
package dbg2w_pkg;
    localparam int DATA_W        = 32;
    localparam int HDR_BITS      = 8;
    localparam int ACK_W         = 3;
    localparam int SLOT_TRN_A    = HDR_BITS;                 // turnaround after header
    localparam int SLOT_ACK0     = SLOT_TRN_A + 1;           // first target ack slot
    localparam int SLOT_TRN_B    = SLOT_ACK0 + ACK_W;        // turnaround / decision slot
    localparam int SLOT_WDATA    = SLOT_TRN_B + 1;           // first host data slot
    localparam int SLOT_LAST     = SLOT_WDATA + DATA_W;      // last slot of a full transfer
    localparam int SLOT_W        = $clog2(SLOT_LAST + 2);

    localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
    localparam logic [3:0]       STAT_PERR = 4'h8;

    // Builds the header word; bit 0 leaves the host first.
    function automatic logic [HDR_BITS-1:0] make_header(input logic ap, input logic rd,
                                                         input logic [1:0] addr);
        return {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
    endfunction
endpackage

// File: rtl/dbg2w_tick.sv
// Half-period tick generator for the link clock.
// Assumes div is held constant while en is high; the counter restarts
// whenever en is low so the first tick comes div+1 cycles after enable.
module dbg2w_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    // Counts system cycles inside one link half period.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!en || tick)   cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // R8: the half-period counter never passes its limit
    assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= div));
endmodule

// File: rtl/dbg2w_rxcap.sv
// Capture registers for bits the target drives: acknowledge and read data.
// Both shift right so the first received bit ends up in bit 0.
// Assumes the caller enables at most one of the two captures per cycle.
module dbg2w_rxcap #(
    parameter int DATA_W = 32,
    parameter int ACK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_ack,
    input  logic              cap_dat,
    input  logic              di,
    output logic [ACK_W-1:0]  ack_q,
    output logic [ACK_W-1:0]  ack_next,
    output logic [DATA_W-1:0] rdata,
    output logic              perr
);
    logic [ACK_W-1:0] ack_sr;
    logic [DATA_W:0]  dat_sr;

    // Shifts in acknowledge or data bits, cleared at each new request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ack_sr <= '0;
            dat_sr <= '0;
        end else begin
            if (cap_ack) ack_sr <= {di, ack_sr[ACK_W-1:1]};
            if (cap_dat) dat_sr <= {di, dat_sr[DATA_W:1]};
        end
    end

    assign ack_q    = ack_sr;
    assign ack_next = {di, ack_sr[ACK_W-1:1]};
    assign rdata    = dat_sr[DATA_W-1:0];
    assign perr     = ^dat_sr;

    // R5: acknowledge and data captures never coincide
    assert_cap_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_ack && cap_dat));
endmodule

// File: rtl/dbg2w_txmux.sv
// Chooses the host's line value and drive enable for a given slot.
// Assumes slot is the slot whose falling edge is being processed.
module dbg2w_txmux
    import dbg2w_pkg::*;
(
    input  logic [SLOT_W-1:0]   slot,
    input  logic [HDR_BITS-1:0] hdr,
    input  logic [DATA_W:0]     wvec,
    input  logic                is_rd,
    output logic                do_o,
    output logic                oe_o
);
    localparam logic [SLOT_W-1:0] S_HDR_END = SLOT_W'(HDR_BITS);
    localparam logic [SLOT_W-1:0] S_WDATA   = SLOT_W'(SLOT_WDATA);
    localparam logic [SLOT_W-1:0] S_LAST    = SLOT_W'(SLOT_LAST);

    logic [SLOT_W-1:0] widx;
    assign widx = slot - S_WDATA;

    // Header slots, host data slots on writes, released line elsewhere.
    always_comb begin
        do_o = 1'b0;
        oe_o = 1'b0;
        if (slot < S_HDR_END) begin
            oe_o = 1'b1;
            do_o = hdr[slot[2:0]];
        end else if (!is_rd && slot >= S_WDATA && slot <= S_LAST) begin
            oe_o = 1'b1;
            do_o = wvec[widx];
        end
    end
endmodule

// File: rtl/dbg2w_engine.sv
// Host-side transaction engine for a two-wire serial debug link.
// Accepts one request while idle, runs header, turnaround, acknowledge and
// (on an OK acknowledge) the 33-bit data phase, then pulses done.
// Assumes the target follows the edge rules: it samples on rising link
// edges and changes its own bits on rising link edges.
module dbg2w_engine
    import dbg2w_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              req_valid,
    input  logic              req_ap,
    input  logic              req_rd,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [ACK_W-1:0]  rsp_ack,
    output logic [3:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_perr,
    output logic              lnk_clk,
    output logic              lnk_do,
    output logic              lnk_oe,
    input  logic              lnk_di
);
    localparam logic [SLOT_W-1:0] S_TRN_A   = SLOT_W'(SLOT_TRN_A);
    localparam logic [SLOT_W-1:0] S_ACK_SMP = SLOT_W'(SLOT_ACK0 + 1);
    localparam logic [SLOT_W-1:0] S_TRN_B   = SLOT_W'(SLOT_TRN_B);
    localparam logic [SLOT_W-1:0] S_WDATA   = SLOT_W'(SLOT_WDATA);
    localparam logic [SLOT_W-1:0] S_LAST    = SLOT_W'(SLOT_LAST);

    logic                busy_q, done_q, rise_next;
    logic [SLOT_W-1:0]   slot_q, end_q, end_p1;
    logic                clk_q, do_q, oe_q;
    logic                rd_q;
    logic [HDR_BITS-1:0] hdr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DIV_W-1:0]    div_q;
    logic [ACK_W-1:0]    rsp_ack_q;
    logic [DATA_W-1:0]   rsp_rdata_q;
    logic                rsp_perr_q;

    logic                tick, tx_do, tx_oe, accept, fall_act, finishing;
    logic                cap_ack, cap_dat, perr_w;
    logic [ACK_W-1:0]    ack_q, ack_next;
    logic [DATA_W-1:0]   rdata_w;
    logic [DATA_W:0]     wvec;

    assign accept    = req_valid && !busy_q;
    assign end_p1    = end_q + 1'b1;
    assign finishing = busy_q && tick && !rise_next && (slot_q == end_p1);
    assign fall_act  = busy_q && tick && !rise_next && (slot_q != end_p1);
    assign cap_ack   = fall_act && slot_q >= S_ACK_SMP && slot_q <= S_TRN_B;
    assign cap_dat   = fall_act && rd_q && slot_q >= S_WDATA && slot_q <= S_LAST;
    assign wvec      = {^wdata_q, wdata_q};

    dbg2w_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(busy_q), .div(div_q), .tick(tick)
    );

    dbg2w_txmux txmux_i (
        .slot(slot_q), .hdr(hdr_q), .wvec(wvec), .is_rd(rd_q),
        .do_o(tx_do), .oe_o(tx_oe)
    );

    dbg2w_rxcap #(.DATA_W(DATA_W), .ACK_W(ACK_W)) rxcap_i (
        .clk(clk), .rst_n(rst_n), .clr(accept), .cap_ack(cap_ack), .cap_dat(cap_dat),
        .di(lnk_di), .ack_q(ack_q), .ack_next(ack_next), .rdata(rdata_w), .perr(perr_w)
    );

    // Latches the request fields and divider at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            hdr_q   <= '0;
            wdata_q <= '0;
            div_q   <= '0;
        end else if (accept) begin
            rd_q    <= req_rd;
            hdr_q   <= make_header(req_ap, req_rd, req_addr);
            wdata_q <= req_wdata;
            div_q   <= div_cfg;
        end
    end

    // Sequences slots: falls launch host bits, rises advance the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            rise_next <= 1'b0;
            slot_q    <= '0;
            end_q     <= S_LAST;
        end else begin
            done_q <= finishing;
            if (accept) begin
                busy_q    <= 1'b1;
                rise_next <= 1'b0;
                slot_q    <= '0;
                end_q     <= S_LAST;
            end else if (busy_q && tick) begin
                if (rise_next) begin
                    slot_q    <= slot_q + 1'b1;
                    rise_next <= 1'b0;
                end else if (finishing) begin
                    busy_q <= 1'b0;
                end else begin
                    rise_next <= 1'b1;
                    if (slot_q == S_TRN_B && ack_next != ACK_OK) end_q <= S_TRN_B;
                end
            end
        end
    end

    // Drives the link pins: clock low and new data on falls, clock high on rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b1;
            do_q  <= 1'b0;
            oe_q  <= 1'b1;
        end else if (busy_q && tick) begin
            if (rise_next) begin
                clk_q <= 1'b1;
            end else if (finishing) begin
                do_q <= 1'b0;
                oe_q <= 1'b1;
            end else begin
                clk_q <= 1'b0;
                do_q  <= tx_do;
                oe_q  <= tx_oe;
            end
        end
    end

    // Registers the response when the transfer finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ack_q   <= '0;
            rsp_rdata_q <= '0;
            rsp_perr_q  <= 1'b0;
        end else if (finishing) begin
            rsp_ack_q   <= ack_q;
            rsp_rdata_q <= rdata_w;
            rsp_perr_q  <= rd_q && (ack_q == ACK_OK) && perr_w;
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign rsp_ack    = rsp_ack_q;
    assign rsp_rdata  = rsp_rdata_q;
    assign rsp_perr   = rsp_perr_q;
    assign rsp_status = rsp_perr_q ? STAT_PERR : {1'b0, rsp_ack_q};
    assign lnk_clk    = clk_q;
    assign lnk_do     = do_q;
    assign lnk_oe     = oe_q;

    // R2: idle link has clock high and host driving
    assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (clk_q && oe_q));

    // R8: link clock only moves on a divider tick
    assert_clk_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && tick) |=> $stable(clk_q));

    // R3: line released during turnaround and acknowledge slots
    assert_trn_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !clk_q && slot_q >= S_TRN_A && slot_q <= S_TRN_B) |-> !oe_q);

    // R7: a short transfer never drives data
    assert_short_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && end_q == S_TRN_B) |-> !oe_q);

    // R9: done lasts one cycle and only when idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
endmodule

// File: tb/dbg2w_engine_tb.sv
`timescale 1ns/1ps
module dbg2w_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_cfg = '0;
    logic        req_valid = 1'b0, req_ap = 1'b0, req_rd = 1'b0;
    logic [1:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, rsp_perr, lnk_clk, lnk_do, lnk_oe;
    logic        lnk_di;
    logic [2:0]  rsp_ack;
    logic [3:0]  rsp_status;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;

    // target model configuration and observations
    logic        tgt_rd;
    logic [2:0]  tgt_ack;
    logic [31:0] tgt_rdata;
    logic        tgt_bad;
    logic [7:0]  hdr_cap;
    logic [32:0] wcap;
    logic        oe_bad;
    int          rises;

    always #2.5 clk = ~clk;

    dbg2w_engine #(.DIV_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .req_valid(req_valid),
        .req_ap(req_ap), .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rsp_ack(rsp_ack), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .lnk_clk(lnk_clk),
        .lnk_do(lnk_do), .lnk_oe(lnk_oe), .lnk_di(lnk_di)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Target responder: samples host bits and drives its own on rising link edges.
    initial begin
        lnk_di = 1'b1;
        forever begin
            @(posedge busy);
            rises = 0; oe_bad = 1'b0; hdr_cap = '0; wcap = '0;
            while (1) begin
                int  k;
                logic exp_oe;
                @(posedge lnk_clk or negedge busy);
                if (!busy) break;
                k = rises;
                exp_oe = (k < 8) ? 1'b1 : (k < 13) ? 1'b0 : !tgt_rd;
                if (lnk_oe !== exp_oe) oe_bad = 1'b1;
                if (k < 8) hdr_cap[k] = lnk_do;
                if (k >= 13 && k <= 45) wcap[k-13] = lnk_do;
                if (k >= 9 && k <= 11) lnk_di = tgt_ack[k-9];
                else if (tgt_rd && tgt_ack == 3'b001 && k >= 12 && k <= 43) lnk_di = tgt_rdata[k-12];
                else if (tgt_rd && tgt_ack == 3'b001 && k == 44) lnk_di = (^tgt_rdata) ^ tgt_bad;
                else lnk_di = 1'b1;
                rises = rises + 1;
            end
            lnk_di = 1'b1;
        end
    end

    // Runs one transfer and judges every observable result.
    task automatic run_txn(input logic ap, input logic rd, input logic [1:0] addr,
                           input logic [31:0] wdata, input logic [2:0] ack,
                           input logic [31:0] rdata, input logic bad,
                           input logic [7:0] div, input bit poke);
        int n, slots, exp_cycles;
        logic [7:0] exp_hdr;
        logic [3:0] exp_status;
        bit ok_ack;
        ok_ack = (ack == 3'b001);
        tgt_rd = rd; tgt_ack = ack; tgt_rdata = rdata; tgt_bad = bad;
        @(negedge clk);
        div_cfg = div; req_ap = ap; req_rd = rd; req_addr = addr; req_wdata = wdata;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            n++;
            if (poke && n == 7) begin
                req_valid = 1'b1; req_ap = ~ap; req_rd = ~rd; req_addr = ~addr;
                req_wdata = ~wdata; div_cfg = div + 8'd3;
            end
            if (poke && n == 9) req_valid = 1'b0;
            @(negedge clk);
        end
        slots = ok_ack ? 46 : 13;
        exp_cycles = (div + 1) * (2 * slots + 1);
        exp_hdr = {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
        exp_status = (rd && ok_ack && bad) ? 4'h8 : {1'b0, ack};
        chk(hdr_cap == exp_hdr, "R1 header", 64'(hdr_cap), 64'(exp_hdr));
        chk(n == exp_cycles, "R8 busy length", 64'(n), 64'(exp_cycles));
        chk(done === 1'b1, "R9 done after busy", 64'(done), 64'd1);
        chk(rises == slots, ok_ack ? "R4 slot count" : "R7 slot count", 64'(rises), 64'(slots));
        chk(!oe_bad, "R3 line direction per slot", 64'(oe_bad), 64'd0);
        chk(rsp_ack == ack, "R3 ack capture", 64'(rsp_ack), 64'(ack));
        chk(rsp_status == exp_status, "R6 status", 64'(rsp_status), 64'(exp_status));
        chk(rsp_perr == (rd && ok_ack && bad), "R6 parity flag", 64'(rsp_perr),
            64'(rd && ok_ack && bad));
        if (rd && ok_ack)
            chk(rsp_rdata == rdata, "R5 read word", 64'(rsp_rdata), 64'(rdata));
        else
            chk(rsp_rdata == 32'd0, "R7 read word zero", 64'(rsp_rdata), 64'd0);
        if (!rd && ok_ack)
            chk(wcap == {^wdata, wdata}, "R4 write bits", 64'(wcap), 64'({^wdata, wdata}));
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b0 && lnk_clk && lnk_oe, "R9 ignored request leaves idle",
                64'({busy, lnk_clk, lnk_oe}), 64'b011);
            chk(rsp_status == exp_status, "R9 response held", 64'(rsp_status), 64'(exp_status));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9 reset idle", 64'({busy, done}), 64'd0);
        chk(lnk_clk == 1'b1 && lnk_oe == 1'b1, "R2 reset pins", 64'({lnk_clk, lnk_oe}), 64'b11);
        // full transfers over every header combination and three dividers
        for (int i = 0; i < 16; i++) begin
            logic [31:0] wd, rdv;
            wd  = (32'h9E3779B9 * (i + 1)) ^ (32'h1 << i);
            rdv = {wd[15:0], ~wd[31:16]};
            run_txn(i[0], i[1], i[3:2], wd, 3'b001, rdv, i[1] & i[3], 8'(i % 3), 1'b0);
            chk(lnk_clk && lnk_oe, "R2 idle between transfers", 64'({lnk_clk, lnk_oe}), 64'b11);
        end
        // every non-OK acknowledge for both directions
        for (int j = 0; j < 7; j++) begin
            for (int d = 0; d < 2; d++) begin
                run_txn(j[0], d[0], j[1:0], 32'hA5A50000 | 32'(j), 3'(j + 2),
                        32'hFFFF_FFFF, 1'b1, 8'(j % 3), 1'b0);
            end
        end
        // requests arriving mid-transfer are ignored
        run_txn(1'b1, 1'b0, 2'b10, 32'h8000_0001, 3'b001, 32'h0, 1'b0, 8'd1, 1'b1);
        run_txn(1'b0, 1'b1, 2'b01, 32'h0, 3'b001, 32'h7FFF_FFFE, 1'b0, 8'd2, 1'b1);
        run_txn(1'b1, 1'b1, 2'b11, 32'h0, 3'b100, 32'h0, 1'b0, 8'd0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule